// File: doc/BRIEF.md
# Per-Bit Multi-Output Interrupt Group

This block collects up to 32 level-type interrupt source lines and turns their enabled rising edges into events for a group of ten separate output lines. The low ten bits of the event vector, of a status word, of a mask and of a pending word all belong to one output each: bit i drives output i. The outputs are handled one at a time. An event on bit i is held back when that bit is already outstanding or masked. Acknowledging bit i either replays its held-back event or drops output i. None of this affects the other nine bits.

Software sees two 32-bit words. The enable word sits at byte offset 0x0 and the status word at byte offset 0x4. Each enable write does exactly one of three things: a first write of zero is stored without effect, a write that adds new bits widens the set of enabled lines, and a write that adds no new bits masks or unmasks bits. In the mask/unmask case the bits are selected by XOR against the previously written value. Writes to the status word acknowledge events. Source bits 10 to 31 can be enabled, but they never reach an output.

Top module: `perbit_irq_group`

## Requirements
- R1: After reset all ten outputs are low, and reads of the enable word (offset 0x0) and the status word (offset 0x4) return zero.
- R2: An enable write whose value adds bits not yet enabled ORs those bits into the enabled set. A later read of offset 0x0 returns the value last written.
- R3: An event on source bit j occurs in a cycle where `src_i[j]` is high, was low in the previous cycle, and bit j was enabled before that cycle's write. A rising edge on a line that is not enabled changes nothing.
- R4: Take an event on bit i (i < 10) where status bit i and mask bit i are both clear. Status bit i reads 1 and `irq_o[i]` is high from the clock edge that samples the event.
- R5: Take an event on bit i where status bit i or mask bit i is set. Status and the outputs stay unchanged, and the event is recorded as pending for bit i.
- R6: A write of zero to the status word has no effect.
- R7: A status write that is neither zero nor all ones clears the written-1 bits. For each written bit i that has a pending event, status bit i is set again, the pending event is consumed, and `irq_o[i]` is high after the edge.
- R8: For each written-1 bit i of such a status write that has no pending event, `irq_o[i]` goes low. Outputs of bits that were not written are untouched.
- R9: A status write of all ones (0xFFFFFFFF) clears the whole status word. It leaves the outputs and the pending events as they were.
- R10: Take an enable write that adds no new enabled bits, and let C be that value XOR the previous written value. If C AND the value is nonzero, the C bits are unmasked. Otherwise the C bits are masked.
- R11: Events on source bits 10 to 31 never set status, pending or any output.
- R12: When a register write and an event fall in the same cycle, the write takes effect first and the event is judged against the result. If both change `irq_o[i]`, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source lines |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 4 | Byte offset: 0x0 enable word, 0x4 status word, others ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word selected by `addr_i`, combinational |
| irq_o | output | 10 | Output lines, bit i per status bit i |

## Verification
The pending and mask bits are not visible at the ports. An error in either shows up only later. A lost pending bit appears at the next acknowledge of that bit: the output falls when it should stay high with status re-set. A stale mask bit appears at the next rising edge of that source: status stays clear and no output rises. The bench therefore replays every held-back event through an acknowledge. After each edge it compares the outputs and the read word against a behavioural model, so a divergence is seen on the first acknowledge or event that depends on the corrupted bit.

// File: rtl/perbit_irq_group.sv
module perbit_irq_group #(
  parameter int N_SRC  = 32,
  parameter int N_OUT  = 10,
  parameter int AW     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic [N_OUT-1:0] irq_o
);
  localparam logic [AW-1:0] OFF_EN = AW'(0);
  localparam logic [AW-1:0] OFF_ST = AW'(4);
  localparam int            PADW   = N_SRC - N_OUT;

  logic [N_SRC-1:0] en_q, en_n, shadow_q, shadow_n, src_q, chg;
  logic [N_OUT-1:0] mask_q, mask_n, stat_q, stat_n, pend_q, pend_n, irq_q, irq_n;
  logic [N_OUT-1:0] stat_w, pend_w, irq_w, ev;
  logic             wr_en_reg, wr_st;

  assign wr_en_reg = wr_en_i && (addr_i == OFF_EN);
  assign wr_st     = wr_en_i && (addr_i == OFF_ST) && (wdata_i != '0);
  assign chg       = shadow_q ^ wdata_i;
  assign ev        = src_i[N_OUT-1:0] & ~src_q[N_OUT-1:0] & en_q[N_OUT-1:0];

  always_comb begin
    en_n     = en_q;
    shadow_n = shadow_q;
    mask_n   = mask_q;
    if (wr_en_reg) begin
      shadow_n = wdata_i;
      if (!(wdata_i == '0 && en_q == '0)) begin
        if ((en_q | wdata_i) != en_q)
          en_n = en_q | wdata_i;
        else if ((chg & wdata_i) != '0)
          mask_n = mask_q & ~chg[N_OUT-1:0];
        else
          mask_n = mask_q | chg[N_OUT-1:0];
      end
    end
  end

  always_comb begin
    stat_w = stat_q;
    pend_w = pend_q;
    irq_w  = irq_q;
    if (wr_st) begin
      stat_w = stat_q & ~wdata_i[N_OUT-1:0];
      if (wdata_i != '1) begin
        for (int i = 0; i < N_OUT; i++) begin
          if (wdata_i[i]) begin
            if (pend_q[i]) begin
              stat_w[i] = 1'b1;
              pend_w[i] = 1'b0;
              irq_w[i]  = 1'b1;
            end else begin
              irq_w[i]  = 1'b0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    stat_n = stat_w;
    pend_n = pend_w;
    irq_n  = irq_w;
    for (int i = 0; i < N_OUT; i++) begin
      if (ev[i]) begin
        if (mask_n[i] || stat_w[i]) begin
          pend_n[i] = 1'b1;
        end else begin
          stat_n[i] = 1'b1;
          irq_n[i]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      shadow_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      pend_q   <= '0;
      irq_q    <= '0;
      src_q    <= '0;
    end else begin
      en_q     <= en_n;
      shadow_q <= shadow_n;
      mask_q   <= mask_n;
      stat_q   <= stat_n;
      pend_q   <= pend_n;
      irq_q    <= irq_n;
      src_q    <= src_i;
    end
  end

  assign irq_o   = irq_q;
  assign rdata_o = (addr_i == OFF_EN) ? shadow_q :
                   (addr_i == OFF_ST) ? {{PADW{1'b0}}, stat_q} : '0;
endmodule

// File: rtl/perbit_irq_group_chk.sv
module perbit_irq_group_chk #(
  parameter int N_SRC = 32,
  parameter int N_OUT = 10,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [N_SRC-1:0] wdata_i,
  input logic [N_OUT-1:0] irq_o,
  input logic [N_SRC-1:0] en_q,
  input logic [N_OUT-1:0] stat_q,
  input logic [N_OUT-1:0] pend_q
);
  logic [N_SRC-1:0] src_prev;
  logic             seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_prev <= '0;
      seen     <= 1'b0;
    end else begin
      src_prev <= src_i;
      seen     <= 1'b1;
    end
  end

  logic no_rise, st_wr, st_ack;
  assign no_rise = (src_i & ~src_prev) == '0;
  assign st_wr   = wr_en_i && (addr_i == AW'(4));
  assign st_ack  = st_wr && (wdata_i != '0) && (wdata_i != '1);

  AST_NEW_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((irq_o & ~$past(irq_o)) & ~stat_q) == '0);  // R4

  AST_QUIET_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && (src_i[N_OUT-1:0] & ~src_prev[N_OUT-1:0] & en_q[N_OUT-1:0]) == '0)
      |=> $stable(stat_q) && $stable(pend_q) && $stable(irq_o));  // R3

  AST_ZERO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wdata_i == '0 && no_rise) |=> $stable(stat_q) && $stable(irq_o) && $stable(pend_q));  // R6

  AST_ALLONES_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wdata_i == '1 && no_rise) |=> stat_q == '0 && $stable(irq_o) && $stable(pend_q));  // R9

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ack && no_rise) |=> (irq_o & $past(wdata_i[N_OUT-1:0] & ~pend_q)) == '0);  // R8

  AST_ACK_REPLAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ack && no_rise) |=> (stat_q & irq_o & $past(wdata_i[N_OUT-1:0] & pend_q))
                            == $past(wdata_i[N_OUT-1:0] & pend_q));  // R7
endmodule

bind perbit_irq_group perbit_irq_group_chk #(.N_SRC(N_SRC), .N_OUT(N_OUT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .en_q(en_q), .stat_q(stat_q), .pend_q(pend_q));

// File: tb/tb_perbit_irq_group.sv
module tb_perbit_irq_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  irq;

  perbit_irq_group dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit [31:0] m_en, m_sh, m_srcq;
  bit [9:0]  m_mask, m_stat, m_pend, m_irq;
  bit [31:0] srcv;

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(input bit [3:0] a);
    if (a == 4'h0) return m_sh;
    if (a == 4'h4) return {22'd0, m_stat};
    return 32'd0;
  endfunction

  task automatic model_step(input bit we, input bit [3:0] a, input bit [31:0] d, input bit [31:0] s);
    bit [31:0] rise;
    rise = s & ~m_srcq & m_en;
    m_srcq = s;
    if (we && a == 4'h0) begin
      if (d == 0 && m_en == 0) m_sh = d;
      else if ((m_en | d) != m_en) begin m_en = m_en | d; m_sh = d; end
      else begin
        bit [31:0] c;
        c = m_sh ^ d;
        for (int k = 0; k < 10; k++)
          if (c[k]) m_mask[k] = ((c & d) != 0) ? 1'b0 : 1'b1;
        m_sh = d;
      end
    end
    if (we && a == 4'h4 && d != 0) begin
      for (int k = 0; k < 10; k++) if (d[k]) m_stat[k] = 0;
      if (d != 32'hFFFF_FFFF)
        for (int k = 0; k < 10; k++)
          if (d[k]) begin
            if (m_pend[k]) begin m_stat[k] = 1; m_pend[k] = 0; m_irq[k] = 1; end
            else m_irq[k] = 0;
          end
    end
    for (int k = 0; k < 10; k++)
      if (rise[k]) begin
        if (m_mask[k] || m_stat[k]) m_pend[k] = 1;
        else begin m_stat[k] = 1; m_irq[k] = 1; end
      end
  endtask

  task automatic cyc(input bit we, input bit [3:0] a, input bit [31:0] d);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; src = srcv;
    model_step(we, a, d, srcv);
    @(posedge clk);
    #1;
    check("model irq", {22'd0, irq}, {22'd0, m_irq});
    check("model rdata", rdata, m_read(a));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq after reset", {22'd0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 4'h0, 0); check("R1 enable reads 0", rdata, 0);
    cyc(0, 4'h4, 0); check("R1 status reads 0", rdata, 0);

    cyc(1, 4'h0, 32'h0000_0C03);
    cyc(0, 4'h0, 0); check("R2 enable readback", rdata, 32'h0000_0C03);

    srcv = 32'h1; cyc(0, 4'h4, 0);
    check("R4 status set", rdata, 32'h1); check("R4 irq up", {22'd0, irq}, 32'h1);

    srcv = 32'h5; cyc(0, 4'h4, 0);
    check("R3 disabled line ignored status", rdata, 32'h1);
    check("R3 disabled line ignored irq", {22'd0, irq}, 32'h1);

    srcv = 32'h0; cyc(0, 4'h4, 0);
    srcv = 32'h1; cyc(0, 4'h4, 0);
    check("R5 status unchanged", rdata, 32'h1);

    cyc(1, 4'h4, 0); cyc(0, 4'h4, 0);
    check("R6 zero write ignored", rdata, 32'h1);

    cyc(1, 4'h4, 32'h1);
    check("R7 replay status", rdata, 32'h1); check("R7 replay irq", {22'd0, irq}, 32'h1);
    cyc(1, 4'h4, 32'h1);
    check("R8 ack status", rdata, 0); check("R8 ack irq", {22'd0, irq}, 0);

    srcv = 32'h401; cyc(0, 4'h4, 0);
    check("R11 upper bit status", rdata, 0); check("R11 upper bit irq", {22'd0, irq}, 0);

    cyc(1, 4'h0, 32'h0000_0C01);
    srcv = 32'h403; cyc(0, 4'h4, 0);
    check("R10 masked event status", rdata, 0); check("R10 masked event irq", {22'd0, irq}, 0);
    cyc(1, 4'h0, 32'h0000_0C03);
    srcv = 32'h402; cyc(0, 4'h4, 0);
    srcv = 32'h403; cyc(0, 4'h4, 0);
    check("R10 unmasked bit0 fires", {22'd0, irq}, 32'h1);
    cyc(1, 4'h4, 32'h3);
    check("R7 per-bit replay status", rdata, 32'h2); check("R8 per-bit irq", {22'd0, irq}, 32'h2);

    srcv = 32'h401; cyc(0, 4'h4, 0);
    srcv = 32'h403; cyc(0, 4'h4, 0);
    cyc(1, 4'h4, 32'hFFFF_FFFF);
    check("R9 status cleared", rdata, 0); check("R9 irq kept", {22'd0, irq}, 32'h2);

    srcv = 32'h401; cyc(0, 4'h4, 0);
    srcv = 32'h403; cyc(0, 4'h4, 0);
    cyc(1, 4'h4, 32'h2);
    srcv = 32'h401; cyc(0, 4'h4, 0);
    srcv = 32'h403; cyc(1, 4'h4, 32'h2);
    check("R12 write then event status", rdata, 32'h2);
    check("R12 write then event irq", {22'd0, irq}, 32'h2);

    for (int n = 0; n < 2000; n++) begin
      int r;
      bit [31:0] d;
      r = $urandom_range(0, 9);
      srcv = srcv ^ (32'h1 << $urandom_range(0, 11));
      d = $urandom;
      if (r < 2) d = d & 32'h3FF;
      if (r == 9) d = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF : 32'h0;
      if (r < 3)       cyc(1, 4'h0, (r == 0) ? (m_sh ^ (32'h1 << $urandom_range(0, 9))) : d);
      else if (r < 7)  cyc(1, 4'h4, d & 32'h3FF);
      else if (r == 9) cyc(1, 4'h4, d);
      else             cyc(0, ($urandom_range(0, 1) == 1) ? 4'h4 : 4'h0, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule